// File: doc/BRIEF.md
# Paged Register Two-Wire Target

This block is the serial front end of a small display controller. It listens on a two-wire bus (I2C) and answers one 7-bit device address. The upper five bits of that address are fixed. The lower two come from a strap input that tells the block how its address pin is wired. The block oversamples both bus lines with its own system clock. It finds START and STOP conditions, shifts bytes in and out MSB first, and pulls SDA low through an open-drain enable whenever it acknowledges a byte or sends a zero.

Behind the bus sits a paged register space. A command register at byte address FDh chooses the page that all later accesses reach: one of eight frame pages, or the function page. A write transaction carries a register address byte and then any number of data bytes. The internal pointer steps by one after each data byte. A read first writes the register address, then issues a repeated START with the read bit set. Frame pages can only be read while the device is in software shutdown; outside shutdown a frame read returns zero. Downstream storage sees a plain register bus: page, address, write data, a one-cycle write strobe, and combinational read data.

Top module: `paged_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 11101 followed by the two strap-derived bits. Bit 0 of that byte selects the transfer direction: 0 means write, 1 means read.
- R2: The strap code sets the two low address bits as follows: code 0 (ground) gives 00, code 1 (supply) gives 11, code 2 (clock line) gives 01, and code 3 (data line) gives 10.
- R3: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. Bits are taken while SCL is high, MSB first. A STOP in the middle of a byte discards that byte.
- R4: The block holds SDA low for the whole ninth clock after three kinds of byte: a matching address byte, a register address byte, and each write data byte. It releases SDA at the end of that ninth clock. Out of reset, SDA is released.
- R5: The register pointer steps by one at the end of the acknowledge of each data byte it receives. During reads, it steps by one on each master acknowledge.
- R6: A data byte written to address FDh changes the page. Value 00h–07h selects frame pages 0–7, and 0Bh selects the function page. Any other value leaves the page unchanged. Writes to FDh never produce a write strobe. The page is 00h after reset.
- R7: Reading address FDh returns the current page code.
- R8: A read from a frame page returns 00h unless the shutdown input is 1. A read from the function page returns storage data whatever the shutdown input is.
- R9: A read returns the storage byte for the selected page and pointer, MSB first. After a master acknowledge, the next byte comes from the following address.
- R10: After an address byte that does not match, the block does not acknowledge and neither writes nor drives SDA until the next START.
- R11: After a master NACK on a read byte, the block releases SDA and stays off the bus until a STOP or a repeated START.
- R12: Each accepted data byte to any address other than FDh produces exactly one single-cycle write strobe. The strobe carries the page, the pointer and the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| strapCode | input | 2 | Address pin wiring: 0 ground, 1 supply, 2 clock line, 3 data line |
| shutdown | input | 1 | Software shutdown state; 1 allows frame-page reads |
| regPage | output | 4 | Selected page code (0–7 frame, 11 function) |
| regAddr | output | 8 | Register pointer |
| regWdata | output | 8 | Write data for storage |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Storage read data for regPage/regAddr |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, device bits 11101, the command register at FDh, function code 0Bh and eight frames. With a bus quarter-period of eight system clocks, every bus edge is seen well after the synchronizer latency. All four strap codes can be swept in one run. The default command address at the top of the byte range lets a data stream run through FDh and on to FEh, so a page switch and a write on the new page can be checked inside a single burst.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int PAGE_W    = 4;
  localparam int BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } pit_state_e;

  // strobes from control to datapath, valid for one clk
  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter, count bit
    logic clrCnt;    // restart the bit counter
    logic loadPtr;   // pointer takes the received byte
    logic incPtr;    // pointer steps by one
    logic cmdWrite;  // received byte goes to the page register
    logic regWrite;  // received byte goes to storage
    logic loadTx;    // transmit shifter takes the read value
    logic shiftTx;   // transmit shifter moves to its next bit
  } pit_strobe_t;

  // strap wiring code -> low address bits
  function automatic logic [1:0] strapBits(input logic [1:0] code);
    case (code)
      2'd0:    return 2'b00;
      2'd1:    return 2'b11;
      2'd2:    return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/pit_line_sync.sv
module pit_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclPipe;
  logic [TOP:0] sdaPipe;
  logic         sclPrev;
  logic         sdaPrev;

  // idle bus is high, so reset to ones to avoid a false START
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[TOP-1:0], sclIn};
      sdaPipe <= {sdaPipe[TOP-1:0], sdaIn};
      sclPrev <= sclPipe[TOP];
      sdaPrev <= sdaPipe[TOP];
    end
  end

  assign sclLvl  = sclPipe[TOP];
  assign sdaLvl  = sdaPipe[TOP];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaLvl,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        byteDone,
  input  logic        addrMatch,
  input  logic        rwBit,
  input  logic        ptrIsCmd,
  output pit_strobe_t st,
  output logic        ackDrive,
  output logic        txActive
);

  pit_state_e state, stateNext;
  logic ackNext, txNext, masterAck, masterAckNext;

  always_comb begin
    st            = '0;
    stateNext     = state;
    ackNext       = ackDrive;
    txNext        = txActive;
    masterAckNext = masterAck;
    if (stopEv) begin
      stateNext = ST_IDLE;
      ackNext   = 1'b0;
      txNext    = 1'b0;
    end else if (startEv) begin
      stateNext = ST_ADDR;
      st.clrCnt = 1'b1;
      ackNext   = 1'b0;
      txNext    = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (sclRise) st.shiftIn = 1'b1;
          if (sclFall && byteDone) begin
            st.clrCnt = 1'b1;
            ackNext   = 1'b1;
            case (state)
              ST_ADDR: begin
                if (addrMatch) stateNext = ST_ADDR_ACK;
                else begin
                  stateNext = ST_IDLE;
                  ackNext   = 1'b0;
                end
              end
              ST_REG: begin
                st.loadPtr = 1'b1;
                stateNext  = ST_REG_ACK;
              end
              default: begin
                if (ptrIsCmd) st.cmdWrite = 1'b1;
                else          st.regWrite = 1'b1;
                stateNext = ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackNext   = 1'b0;
            st.clrCnt = 1'b1;
            if (rwBit) begin
              st.loadTx = 1'b1;
              txNext    = 1'b1;
              stateNext = ST_RDATA;
            end else begin
              stateNext = ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          if (sclFall) begin
            ackNext   = 1'b0;
            st.clrCnt = 1'b1;
            stateNext = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) begin
            ackNext   = 1'b0;
            st.clrCnt = 1'b1;
            st.incPtr = 1'b1;
            stateNext = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) st.shiftIn = 1'b1;
          if (sclFall) begin
            if (byteDone) begin
              txNext    = 1'b0;
              st.clrCnt = 1'b1;
              stateNext = ST_RDATA_ACK;
            end else begin
              st.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclRise) begin
            masterAckNext = ~sdaLvl;
            st.incPtr     = ~sdaLvl;
          end
          if (sclFall) begin
            st.clrCnt = 1'b1;
            if (masterAck) begin
              st.loadTx = 1'b1;
              txNext    = 1'b1;
              stateNext = ST_RDATA;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNext;
      ackDrive  <= ackNext;
      txActive  <= txNext;
      masterAck <= masterAckNext;
    end
  end

  AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && sclFall) |=> !ackDrive); // R4

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!ackDrive && !txActive)); // R10

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter logic [4:0] DEV_UPPER   = 5'b11101,
  parameter logic [7:0] CMD_ADDR    = 8'hFD,
  parameter logic [7:0] FUNC_CODE   = 8'h0B,
  parameter int         FRAME_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pit_strobe_t       st,
  input  logic              sdaLvl,
  input  logic [1:0]        strapCode,
  input  logic              shutdown,
  input  logic [7:0]        regRdata,
  output logic              byteDone,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              ptrIsCmd,
  output logic              txBit,
  output logic [PAGE_W-1:0] regPage,
  output logic [7:0]        regAddr,
  output logic [7:0]        regWdata,
  output logic              regWe
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [PAGE_W-1:0] FUNC_PAGE = FUNC_CODE[PAGE_W-1:0];

  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [7:0]        ptr;
  logic [7:0]        wdataQ;
  logic [PAGE_W-1:0] pageQ;
  logic [CNT_W-1:0]  bitCnt;
  logic              weQ;
  logic              cmdLegal;
  logic              onFrame;
  logic [7:0]        readVal;

  assign byteDone  = (bitCnt == CNT_FULL);
  assign addrMatch = (rxShift[7:1] == {DEV_UPPER, strapBits(strapCode)});
  assign rwBit     = rxShift[0];
  assign ptrIsCmd  = (ptr == CMD_ADDR);
  assign cmdLegal  = (rxShift < 8'(FRAME_COUNT)) || (rxShift == FUNC_CODE);
  assign onFrame   = (pageQ != FUNC_PAGE);

  // value placed on the bus when a read byte starts
  always_comb begin
    if (ptrIsCmd)                 readVal = {{(8-PAGE_W){1'b0}}, pageQ};
    else if (onFrame && !shutdown) readVal = 8'h00;
    else                          readVal = regRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else begin
      if (st.shiftIn) rxShift <= {rxShift[6:0], sdaLvl};
      if (st.clrCnt)                     bitCnt <= '0;
      else if (st.shiftIn && !byteDone)  bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      pageQ <= '0;
    end else begin
      if (st.loadPtr)     ptr <= rxShift;
      else if (st.incPtr) ptr <= ptr + 8'd1;
      if (st.cmdWrite && cmdLegal) pageQ <= rxShift[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      wdataQ  <= '0;
      weQ     <= 1'b0;
    end else begin
      if (st.loadTx)       txShift <= readVal;
      else if (st.shiftTx) txShift <= {txShift[6:0], 1'b1};
      weQ <= st.regWrite;
      if (st.regWrite) wdataQ <= rxShift;
    end
  end

  assign txBit    = txShift[7];
  assign regPage  = pageQ;
  assign regAddr  = ptr;
  assign regWdata = wdataQ;
  assign regWe    = weQ;

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R12

  AST_PAGE_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pageQ) |-> $past(st.cmdWrite)); // R6

  AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (({{(8-PAGE_W){1'b0}}, pageQ} < 8'(FRAME_COUNT)) || (pageQ == FUNC_PAGE))); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> ($past(st.loadPtr) || ptr == $past(ptr) + 8'd1)); // R5

endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target
  import pit_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_UPPER   = 5'b11101,
  parameter logic [7:0] CMD_ADDR    = 8'hFD,
  parameter logic [7:0] FUNC_CODE   = 8'h0B,
  parameter int         FRAME_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        strapCode,
  input  logic              shutdown,
  output logic [PAGE_W-1:0] regPage,
  output logic [7:0]        regAddr,
  output logic [7:0]        regWdata,
  output logic              regWe,
  input  logic [7:0]        regRdata
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic byteDone, addrMatch, rwBit, ptrIsCmd, txBit;
  logic ackDrive, txActive;
  pit_strobe_t st;

  pit_line_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  pit_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .byteDone(byteDone), .addrMatch(addrMatch),
    .rwBit(rwBit), .ptrIsCmd(ptrIsCmd), .st(st), .ackDrive(ackDrive), .txActive(txActive)
  );

  pit_datapath #(
    .DEV_UPPER(DEV_UPPER), .CMD_ADDR(CMD_ADDR), .FUNC_CODE(FUNC_CODE), .FRAME_COUNT(FRAME_COUNT)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st), .sdaLvl(sdaLvl), .strapCode(strapCode),
    .shutdown(shutdown), .regRdata(regRdata), .byteDone(byteDone), .addrMatch(addrMatch),
    .rwBit(rwBit), .ptrIsCmd(ptrIsCmd), .txBit(txBit), .regPage(regPage),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe)
  );

  // open-drain: pull low for acknowledge or for a zero data bit
  assign sdaOe = ackDrive | (txActive & ~txBit);

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaOe)); // R3

endmodule

// File: tb/sim_paged_i2c_target.sv
module sim_paged_i2c_target;

  localparam time Q = 160ns;  // 8 system clocks per bus quarter

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [1:0] strapCode = 2'd0;
  logic       shutdown = 1'b0;
  logic       sdaOe;
  logic [3:0] regPage;
  logic [7:0] regAddr, regWdata, regRdata;
  logic       regWe;
  logic       sdaBus;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [19:0] expQ[$];

  always #10ns clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;

  function automatic logic [7:0] modelRd(input logic [3:0] pg, input logic [7:0] ad);
    return {pg, 4'h0} ^ ad ^ 8'h5C;
  endfunction

  assign regRdata = modelRd(regPage, regAddr);

  paged_i2c_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapCode(strapCode), .shutdown(shutdown), .regPage(regPage),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe pops one expected write (R12)
  always @(negedge clk) begin
    if (rstN && regWe) begin
      if (expQ.size() == 0) begin
        chk("R12 unexpected strobe", {12'h0, regPage, regAddr, regWdata}, 32'hFFFFFFFF);
      end else begin
        logic [19:0] item;
        item = expQ.pop_front();
        chk("R12 write item", {12'h0, regPage, regAddr, regWdata}, {12'h0, item});
      end
    end
  end

  task automatic pushWrite(input logic [3:0] pg, input logic [7:0] ad, input logic [7:0] dt);
    expQ.push_back({pg, ad, dt});
  endtask

  task automatic busStart();
    mSda = 1'b1; #Q;
    mScl = 1'b1; #Q;
    mSda = 1'b0; #Q;
    mScl = 1'b0; #Q;
  endtask

  task automatic busStop();
    mSda = 1'b0; #Q;
    mScl = 1'b1; #Q;
    mSda = 1'b1; #Q;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; #Q;
      mScl = 1'b1; #Q;
      mScl = 1'b0; #Q;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    logic ack;
    sendBits(b, 8);
    mSda = 1'b1; #Q;
    mScl = 1'b1; #Q;
    ack = ~sdaBus;
    mScl = 1'b0; #Q;
    chk(req, {31'h0, ack}, {31'h0, expAck});
  endtask

  task automatic recvByte(input logic ackIt, input logic [7:0] exp, input string req);
    logic [7:0] b;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q;
      mScl = 1'b1; #Q;
      b[i] = sdaBus;
      mScl = 1'b0;
    end
    #Q;
    mSda = ackIt ? 1'b0 : 1'b1; #Q;
    mScl = 1'b1; #Q;
    mScl = 1'b0; #Q;
    mSda = 1'b1;
    chk(req, {24'h0, b}, {24'h0, exp});
  endtask

  function automatic logic [7:0] devAddr(input logic [1:0] low, input logic rd);
    return {5'b11101, low, rd};
  endfunction

  task automatic setupRead(input logic [7:0] ra);
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 write address");
    sendByte(ra, 1'b1, "R4 register byte");
    busStart();
    sendByte(devAddr(2'b00, 1'b1), 1'b1, "R1 read address");
  endtask

  initial begin
    #(4ms);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 reset sdaOe", {31'h0, sdaOe}, 32'h0);
    chk("R6 reset page", {28'h0, regPage}, 32'h0);
    chk("R12 reset strobe", {31'h0, regWe}, 32'h0);

    // R3 R5 R12: burst write on page 0
    pushWrite(4'h0, 8'h10, 8'hA5);
    pushWrite(4'h0, 8'h11, 8'h5A);
    pushWrite(4'h0, 8'h12, 8'h3C);
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'h10, 1'b1, "R4 reg ack");
    sendByte(8'hA5, 1'b1, "R4 data ack");
    sendByte(8'h5A, 1'b1, "R5 data ack");
    sendByte(8'h3C, 1'b1, "R5 data ack");
    busStop();
    #Q;
    chk("R5 pointer after burst", {24'h0, regAddr}, 32'h13);

    // R3: STOP mid-byte discards it
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'h30, 1'b1, "R4 reg ack");
    sendBits(8'hE7, 3);
    busStop();
    #Q;
    chk("R3 aborted byte not written", expQ.size(), 0);

    // R6: function page, then reserved value ignored
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'hFD, 1'b1, "R4 reg ack");
    sendByte(8'h0B, 1'b1, "R6 cmd ack");
    busStop();
    chk("R6 function page", {28'h0, regPage}, 32'hB);
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'hFD, 1'b1, "R4 reg ack");
    sendByte(8'h09, 1'b1, "R6 cmd ack");
    busStop();
    chk("R6 reserved ignored", {28'h0, regPage}, 32'hB);

    // R5 R6: burst through FDh into FEh on the new page
    pushWrite(4'h3, 8'hFE, 8'h77);
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'hFD, 1'b1, "R4 reg ack");
    sendByte(8'h03, 1'b1, "R6 cmd ack");
    sendByte(8'h77, 1'b1, "R5 data ack");
    busStop();
    chk("R6 frame page 3", {28'h0, regPage}, 32'h3);

    // R7: read back page code
    setupRead(8'hFD);
    recvByte(1'b0, 8'h03, "R7 page readback");
    busStop();

    // R8: frame read outside shutdown gives zero
    shutdown = 1'b0;
    setupRead(8'h20);
    recvByte(1'b0, 8'h00, "R8 frame read gated");
    busStop();

    // R9 R5: frame read in shutdown, two bytes
    shutdown = 1'b1;
    setupRead(8'h20);
    recvByte(1'b1, modelRd(4'h3, 8'h20), "R9 first byte");
    recvByte(1'b0, modelRd(4'h3, 8'h21), "R5 R9 second byte");
    busStop();

    // R8 R11: function page read outside shutdown, then NACK
    busStart();
    sendByte(devAddr(2'b00, 1'b0), 1'b1, "R1 match ack");
    sendByte(8'hFD, 1'b1, "R4 reg ack");
    sendByte(8'h0B, 1'b1, "R6 cmd ack");
    busStop();
    shutdown = 1'b0;
    setupRead(8'h05);
    recvByte(1'b0, modelRd(4'hB, 8'h05), "R8 function page read");
    recvByte(1'b0, 8'hFF, "R11 released after nack");
    busStop();

    // R10: non-matching address ignored
    busStart();
    sendByte(devAddr(2'b11, 1'b0), 1'b0, "R10 no ack on address");
    sendByte(8'h10, 1'b0, "R10 no ack on reg");
    sendByte(8'h99, 1'b0, "R10 no ack on data");
    busStop();
    chk("R10 no strobe", expQ.size(), 0);

    // R2: strap sweep
    for (int c = 0; c < 4; c++) begin
      logic [1:0] low;
      strapCode = 2'(c);
      low = (c == 0) ? 2'b00 : (c == 1) ? 2'b11 : (c == 2) ? 2'b01 : 2'b10;
      busStart();
      sendByte(devAddr(low, 1'b0), 1'b1, "R2 strap match");
      busStop();
    end
    strapCode = 2'd2;
    busStart();
    sendByte(devAddr(2'b10, 1'b0), 1'b0, "R2 strap mismatch");
    busStop();

    repeat (20) @(negedge clk);
    chk("R12 all writes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule